// File: doc/BRIEF.md
# Banked Register RAM with Return Stack

This block is the 128-byte internal data memory of a small 8-bit controller core. The same array serves three purposes. Two banks of eight working registers sit at fixed places in it. A subroutine return stack, eight entries of two bytes each, sits at another fixed place. Every other byte is ordinary scratch RAM.

The core reaches the memory in three ways. Register access names register n of the bank chosen by `bank_sel`. Indirect access uses the byte held in register 0 or register 1 of the active bank as a RAM address, so it can reach any of the 128 locations. Push and pop save and restore a 16-bit return word through a 3-bit stack pointer. Stack slots above the current nesting depth stay free for use as plain RAM.

One operation is accepted per cycle, chosen by a fixed priority. Read data appears on the cycle after the request.

Top module: `regstack_ram`

## Requirements
- R1: After reset, `sp`, `rd_data` and `pop_data` are 0 and every one of the 128 bytes reads as 0.
- R2: Register access to index n (0 to 7) uses address n when `bank_sel`=0 and address 24+n when `bank_sel`=1. The two banks are separate storage.
- R3: Indirect access uses as its address the byte held in register 0 (`ind_sel`=0) or register 1 (`ind_sel`=1) of the active bank. This reaches every address from 0 to 127, including the register banks themselves.
- R4: An indirect access uses only bits 6:0 of the pointer byte, so a pointer from 128 to 255 reaches the pointer value minus 128.
- R5: The byte read by a register or indirect access appears on `rd_data` one cycle after the request. `rd_data` keeps its value until the next accepted access. When the same access also writes, `rd_data` returns the byte as it was before the write.
- R6: A push writes `push_data[7:0]` to address 8+2·SP and `push_data[15:8]` to address 9+2·SP, then increments SP.
- R7: A pop first decrements SP and then reads addresses 8+2·SP (low byte) and 9+2·SP (high byte). The 16-bit word appears on `pop_data` one cycle later. `pop_data` keeps its value when no pop is accepted.
- R8: SP is 3 bits wide and wraps modulo 8. A ninth push without a pop overwrites the oldest entry and raises no error. A pop at SP=0 moves SP to 7.
- R9: Stack bytes in addresses 8 to 23 can be written and read by indirect access like any other RAM byte, and pushes are visible there.
- R10: In one cycle, only the highest-priority request is carried out, in the order push, pop, indirect, register. Any lower request in the same cycle is ignored: it writes nothing and does not change `rd_data`.
- R11: When push and pop are asserted together, only the push takes effect and SP increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 1 | Active register bank (0: base 0, 1: base 24) |
| reg_en | input | 1 | Register access request |
| reg_idx | input | 3 | Register number within the active bank |
| ind_en | input | 1 | Indirect access request |
| ind_sel | input | 1 | Which pointer register supplies the address (0 or 1) |
| acc_we | input | 1 | The accepted register or indirect access also writes |
| acc_wdata | input | 8 | Write byte for register or indirect access |
| push | input | 1 | Push request |
| push_data | input | 16 | Return word to push |
| pop | input | 1 | Pop request |
| rd_data | output | 8 | Byte read by the last accepted access |
| pop_data | output | 16 | Word read by the last pop |
| sp | output | 3 | Stack pointer |

## Verification
The assertions expect inputs that are stable and known at each rising edge while `rst_n` is high. They allow any mix of simultaneous requests, because the priority order settles every overlap.

The bench drives all inputs on the falling edge, so nothing changes near the sampling edge. It deliberately asserts several requests in the same cycle, which exercises the ignored-request paths without leaving the stated input conditions.

A behavioural model in the bench predicts `sp`, `rd_data` and `pop_data` after every cycle.

// File: rtl/regram_pkg.sv
package regram_pkg;

    // Operation accepted in a cycle, after priority resolution
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_IND  = 3'd3,
        OP_REG  = 3'd4
    } op_e;

endpackage

// File: rtl/regram_array.sv
module regram_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int NWR    = 2,
    parameter int NRD    = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NWR-1:0]                wr_en,
    input  logic [NWR-1:0][AW-1:0]        wr_addr,
    input  logic [NWR-1:0][DATA_W-1:0]    wr_data,
    input  logic [AW-1:0]                 ptr_raddr,
    output logic [DATA_W-1:0]             ptr_rdata,
    input  logic [NRD-1:0][AW-1:0]        rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]    rd_dat
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w]) begin
                mem_d[wr_addr[w]] = wr_data[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ptr_rdata = mem_q[ptr_raddr];

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_dat[r] = mem_q[rd_addr[r]];
    end

    // Two write ports enabled together must target different bytes (push pair)
    for (genvar w = 1; w < NWR; w++) begin : g_wchk
        p_wr_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[0] && wr_en[w]) |-> (wr_addr[0] != wr_addr[w]))
            else $error("write ports collide");
    end

endmodule

// File: rtl/regram_addr_map.sv
module regram_addr_map #(
    parameter int DATA_W     = 8,
    parameter int AW         = 7,
    parameter int IDXW       = 3,
    parameter int BANK1_BASE = 24
) (
    input  logic              bank_sel,
    input  logic [IDXW-1:0]   reg_idx,
    input  logic              ind_sel,
    input  logic [DATA_W-1:0] ptr_val,
    output logic [AW-1:0]     ptr_addr,
    output logic [AW-1:0]     reg_addr,
    output logic [AW-1:0]     ind_addr
);

    logic [AW-1:0] base;

    always_comb begin
        base     = bank_sel ? AW'(BANK1_BASE) : '0;
        reg_addr = base + AW'(reg_idx);
        ptr_addr = base + AW'(ind_sel);
        // Only the low AW bits of the pointer matter: high values fold back
        ind_addr = ptr_val[AW-1:0];
    end

endmodule

// File: rtl/regram_stack_ctrl.sv
module regram_stack_ctrl #(
    parameter int AW         = 7,
    parameter int LVLS       = 8,
    parameter int STACK_BASE = 8,
    localparam int SPW       = $clog2(LVLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    output logic [SPW-1:0] sp,
    output logic [AW-1:0]  push_lo,
    output logic [AW-1:0]  push_hi,
    output logic [AW-1:0]  pop_lo,
    output logic [AW-1:0]  pop_hi
);

    typedef struct packed {
        logic [SPW-1:0] sp;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [SPW-1:0] sp_dec;

    always_comb begin
        stk_d  = stk_q;
        sp_dec = stk_q.sp - SPW'(1);
        if (push) begin
            stk_d.sp = stk_q.sp + SPW'(1);
        end else if (pop) begin
            stk_d.sp = sp_dec;
        end
        push_lo = AW'(STACK_BASE) + AW'({stk_q.sp, 1'b0});
        push_hi = push_lo + AW'(1);
        pop_lo  = AW'(STACK_BASE) + AW'({sp_dec, 1'b0});
        pop_hi  = pop_lo + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign sp = stk_q.sp;

    p_push_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sp == SPW'($past(sp) + SPW'(1))))
        else $error("push did not advance sp");

    p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (sp == SPW'($past(sp) - SPW'(1))))
        else $error("pop did not retreat sp");

    p_both_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push) |=> (sp != $past(sp) - SPW'(1)))
        else $error("pop won over push");

    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp))
        else $error("sp moved while idle");

endmodule

// File: rtl/regstack_ram.sv
module regstack_ram #(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 128,
    parameter int REGS       = 8,
    parameter int BANK1_BASE = 24,
    parameter int STACK_BASE = 8,
    parameter int STACK_LVLS = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int IDXW      = $clog2(REGS),
    localparam int SPW       = $clog2(STACK_LVLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank_sel,
    input  logic                  reg_en,
    input  logic [IDXW-1:0]       reg_idx,
    input  logic                  ind_en,
    input  logic                  ind_sel,
    input  logic                  acc_we,
    input  logic [DATA_W-1:0]     acc_wdata,
    input  logic                  push,
    input  logic [2*DATA_W-1:0]   push_data,
    input  logic                  pop,
    output logic [DATA_W-1:0]     rd_data,
    output logic [2*DATA_W-1:0]   pop_data,
    output logic [SPW-1:0]        sp
);
    import regram_pkg::*;

    localparam int NWR = 2;
    localparam int NRD = 3;

    typedef struct packed {
        logic [DATA_W-1:0]   rd;
        logic [2*DATA_W-1:0] pd;
    } out_t;

    out_t out_d, out_q;
    op_e  op;

    logic [AW-1:0]     ptr_addr, reg_addr, ind_addr, acc_addr;
    logic [DATA_W-1:0] ptr_val;
    logic [AW-1:0]     stk_push_lo, stk_push_hi, stk_pop_lo, stk_pop_hi;

    logic [NWR-1:0]             wr_en;
    logic [NWR-1:0][AW-1:0]     wr_addr;
    logic [NWR-1:0][DATA_W-1:0] wr_data;
    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_dat;

    regram_addr_map #(
        .DATA_W    (DATA_W),
        .AW        (AW),
        .IDXW      (IDXW),
        .BANK1_BASE(BANK1_BASE)
    ) u_map (
        .bank_sel (bank_sel),
        .reg_idx  (reg_idx),
        .ind_sel  (ind_sel),
        .ptr_val  (ptr_val),
        .ptr_addr (ptr_addr),
        .reg_addr (reg_addr),
        .ind_addr (ind_addr)
    );

    regram_stack_ctrl #(
        .AW        (AW),
        .LVLS      (STACK_LVLS),
        .STACK_BASE(STACK_BASE)
    ) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .sp      (sp),
        .push_lo (stk_push_lo),
        .push_hi (stk_push_hi),
        .pop_lo  (stk_pop_lo),
        .pop_hi  (stk_pop_hi)
    );

    regram_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .NWR    (NWR),
        .NRD    (NRD)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr_raddr (ptr_addr),
        .ptr_rdata (ptr_val),
        .rd_addr   (rd_addr),
        .rd_dat    (rd_dat)
    );

    // Priority: push, pop, indirect, register
    always_comb begin
        if (push)        op = OP_PUSH;
        else if (pop)    op = OP_POP;
        else if (ind_en) op = OP_IND;
        else if (reg_en) op = OP_REG;
        else             op = OP_IDLE;
    end

    assign acc_addr = (op == OP_IND) ? ind_addr : reg_addr;
    assign rd_addr  = {stk_pop_hi, stk_pop_lo, acc_addr};

    always_comb begin
        out_d   = out_q;
        wr_en   = '0;
        wr_addr = '0;
        wr_data = '0;
        case (op)
            OP_PUSH: begin
                wr_en      = '1;
                wr_addr[0] = stk_push_lo;
                wr_data[0] = push_data[DATA_W-1:0];
                wr_addr[1] = stk_push_hi;
                wr_data[1] = push_data[2*DATA_W-1:DATA_W];
            end
            OP_POP: begin
                out_d.pd = {rd_dat[2], rd_dat[1]};
            end
            OP_IND, OP_REG: begin
                out_d.rd   = rd_dat[0];
                wr_en[0]   = acc_we;
                wr_addr[0] = acc_addr;
                wr_data[0] = acc_wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.rd;
    assign pop_data = out_q.pd;

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push || pop || (!ind_en && !reg_en)) |=> $stable(rd_data))
        else $error("rd_data changed without an accepted access");

    p_pop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push || !pop) |=> $stable(pop_data))
        else $error("pop_data changed without a pop");

    p_push_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (stk_push_lo >= AW'(STACK_BASE)) &&
                 (stk_push_hi <  AW'(STACK_BASE + 2*STACK_LVLS)))
        else $error("push outside stack window");

    p_pop_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |-> (stk_pop_lo >= AW'(STACK_BASE)) &&
                           (stk_pop_hi <  AW'(STACK_BASE + 2*STACK_LVLS)))
        else $error("pop outside stack window");

endmodule

// File: tb/regstack_ram_tb.sv
module regstack_ram_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_sel, reg_en, ind_en, ind_sel, acc_we, push, pop;
    logic [2:0]  reg_idx;
    logic [7:0]  acc_wdata;
    logic [15:0] push_data;
    logic [7:0]  rd_data;
    logic [15:0] pop_data;
    logic [2:0]  sp;

    always #10 clk = ~clk;

    regstack_ram u_dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_en(reg_en),
        .reg_idx(reg_idx), .ind_en(ind_en), .ind_sel(ind_sel),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .push(push),
        .push_data(push_data), .pop(pop), .rd_data(rd_data),
        .pop_data(pop_data), .sp(sp)
    );

    int checks = 0;
    int fails  = 0;
    int m [128];
    int msp = 0;
    int erd = 0;
    int epop = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp(string tag);
        chk(tag, "sp", int'(sp), msp);
        chk(tag, "rd_data", int'(rd_data), erd);
        chk(tag, "pop_data", int'(pop_data), epop);
    endtask

    // One cycle: drive, update model, wait for the edge, compare after it
    task automatic step(string tag, bit bs, bit re, int idx, bit ie, bit is,
                        bit we, int wd, bit pu, int pd, bit po);
        int base;
        int a;
        bank_sel  = bs;  reg_en = re; reg_idx = idx[2:0];
        ind_en    = ie;  ind_sel = is; acc_we = we; acc_wdata = wd[7:0];
        push      = pu;  push_data = pd[15:0]; pop = po;
        base = bs ? 24 : 0;
        if (pu) begin
            m[8 + 2*msp] = pd & 8'hff;
            m[9 + 2*msp] = (pd >> 8) & 8'hff;
            msp = (msp + 1) % 8;
        end else if (po) begin
            msp  = (msp + 7) % 8;
            epop = (m[9 + 2*msp] << 8) | m[8 + 2*msp];
        end else if (ie || re) begin
            a   = ie ? (m[base + int'(is)] & 127) : (base + (idx & 7));
            erd = m[a];
            if (we) m[a] = wd & 8'hff;
        end
        @(posedge clk);
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wreg(string tag, bit bs, int idx, int v);
        step(tag, bs, 1, idx, 0, 0, 1, v, 0, 0, 0);
    endtask
    task automatic rreg(string tag, bit bs, int idx);
        step(tag, bs, 1, idx, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wind(string tag, bit bs, bit is, int v);
        step(tag, bs, 0, 0, 1, is, 1, v, 0, 0, 0);
    endtask
    task automatic rind(string tag, bit bs, bit is);
        step(tag, bs, 0, 0, 1, is, 0, 0, 0, 0, 0);
    endtask
    task automatic dpush(string tag, int v);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 1, v, 0);
    endtask
    task automatic dpop(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask
    // Read any address through pointer register 0 of bank 0
    task automatic peek(string tag, int addr);
        wreg(tag, 0, 0, addr);
        rind(tag, 0, 0);
        chk(tag, "peek", int'(rd_data), m[addr]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 0;
        rst_n = 1'b0;
        bank_sel = 0; reg_en = 0; reg_idx = 0; ind_en = 0; ind_sel = 0;
        acc_we = 0; acc_wdata = 0; push = 0; push_data = 0; pop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp("R1");
        for (int i = 0; i < 8; i++) rreg("R1", 0, i);
        for (int i = 0; i < 8; i++) rreg("R1", 1, i);
        peek("R1", 100);

        // R2: both banks, separate storage
        for (int i = 0; i < 8; i++) wreg("R2", 0, i, 'h10 + i);
        for (int i = 0; i < 8; i++) wreg("R2", 1, i, 'h30 + i);
        for (int i = 0; i < 8; i++) rreg("R2", 0, i);
        for (int i = 0; i < 8; i++) rreg("R2", 1, i);
        chk("R2", "bank1 r7", int'(rd_data), 'h37);

        // R5: read-before-write and hold
        wreg("R5", 0, 3, 'h99);
        chk("R5", "old value on write", int'(rd_data), 'h13);
        idle("R5");
        idle("R5");
        chk("R5", "held", int'(rd_data), 'h13);
        rreg("R5", 0, 3);
        chk("R5", "new value", int'(rd_data), 'h99);

        // R3: indirect through both pointer registers and both banks
        wreg("R3", 0, 0, 80);
        wreg("R3", 0, 1, 127);
        wind("R3", 0, 0, 'hA5);
        wind("R3", 0, 1, 'h5A);
        rind("R3", 0, 0);
        chk("R3", "ind r0", int'(rd_data), 'hA5);
        rind("R3", 0, 1);
        chk("R3", "ind r1", int'(rd_data), 'h5A);
        wreg("R3", 1, 1, 29);
        rind("R3", 1, 1);
        chk("R3", "ind into bank1", int'(rd_data), 'h35);

        // R4: folding of high pointer values
        wreg("R4", 0, 0, 80 + 128);
        rind("R4", 0, 0);
        chk("R4", "fold 208", int'(rd_data), 'hA5);
        wreg("R4", 1, 0, 255);
        rind("R4", 1, 0);
        chk("R4", "fold 255", int'(rd_data), 'h5A);

        // R6: pushes and their placement
        dpush("R6", 'h1234);
        dpush("R6", 'hABCD);
        dpush("R6", 'h0F0E);
        peek("R6", 8);
        peek("R6", 11);
        chk("R6", "hi of 2nd", int'(rd_data), 'hAB);
        peek("R6", 12);
        chk("R6", "lo of 3rd", int'(rd_data), 'h0E);

        // R9: unused stack bytes as RAM
        wreg("R9", 0, 0, 20);
        wind("R9", 0, 0, 'h77);
        rind("R9", 0, 0);
        chk("R9", "stack byte as ram", int'(rd_data), 'h77);
        wreg("R9", 0, 0, 9);
        wind("R9", 0, 0, 'h56);

        // R7: pops
        dpop("R7");
        chk("R7", "pop 3rd", int'(pop_data), 'h0F0E);
        dpop("R7");
        dpop("R7");
        chk("R7", "pop 1st modified", int'(pop_data), 'h5634);
        idle("R7");
        chk("R7", "pop hold", int'(pop_data), 'h5634);

        // R8: wrap
        for (int i = 0; i < 9; i++) dpush("R8", 'h100 * i + i + 1);
        chk("R8", "sp after nine", int'(sp), 1);
        dpop("R8");
        chk("R8", "ninth overwrote oldest", int'(pop_data), 'h0809);
        dpop("R8");
        chk("R8", "pop at 0 wraps", int'(sp), 7);

        // R10: lower requests ignored
        wreg("R10", 0, 0, 60);
        step("R10", 0, 1, 2, 1, 0, 1, 'hEE, 1, 'h4242, 0);
        peek("R10", 60);
        rreg("R10", 0, 2);
        chk("R10", "reg untouched", int'(rd_data), 'h12);
        step("R10", 0, 1, 2, 0, 0, 1, 'hEE, 0, 0, 1);
        rreg("R10", 0, 2);
        step("R10", 0, 1, 2, 1, 0, 1, 'hCC, 0, 0, 0);
        rreg("R10", 0, 2);
        chk("R10", "ind beats reg", int'(rd_data), 'h12);
        peek("R10", 60);
        chk("R10", "ind wrote", int'(rd_data), 'hCC);

        // R11: push and pop together
        step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 'h6161, 1);
        dpop("R11");
        chk("R11", "push won", int'(pop_data), 'h6161);

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 16);
            step("R10", bit'($urandom % 2), bit'(r[0]), int'($urandom % 8),
                 bit'(r[1]), bit'($urandom % 2), bit'($urandom % 2),
                 int'($urandom % 256), r == 15, int'($urandom % 65536),
                 r[3:2] == 2'b11);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule